// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer in front of a multiplexed successive-approximation converter. A single control write supplies a 4-bit channel field and a 3-bit mode code. The controller then steps the multiplexer select and issues start requests to the converter over a one-at-a-time handshake. Each 10-bit result is filed into one of eight result slots.

The mode code chooses three things: one pass or repeated passes, one fixed channel or an aligned block of channels, and four or eight conversions per pass. Every result slot has a completion flag, and one more flag marks the end of a whole pass. A new control write cancels whatever is running and starts again from slot 0. Of the sixteen channel codes, 0 to 6 select external pins and 7 to 15 select internal sources. The controller treats every code the same way.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied, and until the first control write, `conv_start`, `slot_done` and `seq_done` are 0 and every result slot reads 0.
- R2: A cycle with `cfg_we` high latches `cfg_chan` and `cfg_mode`. At that edge it clears every `slot_done` bit and `seq_done`, and the following cycle raises `conv_start` for slot 0.
- R3: `cfg_mode[0]` sets the pass length: 0 gives four conversions (slots 0 to 3), 1 gives eight (slots 0 to 7).
- R4: With `cfg_mode[1]` = 0, every conversion of the pass selects `conv_sel` equal to the latched channel field.
- R5: With `cfg_mode[1]` = 1, conversion n selects the channel field with its low bits replaced by n. Four-conversion passes replace 2 bits, giving the aligned group of 4. Eight-conversion passes replace 3 bits, giving the aligned group of 8.
- R6: Conversion n of a pass is stored in `res_flat[10n+9:10n]` at the edge where `conv_done` is accepted, and `slot_done[n]` is set at that same edge.
- R7: `seq_done` is set at the edge that stores the last conversion of a pass.
- R8: With `cfg_mode[2]` = 0, no `conv_start` follows the last conversion until the next control write.
- R9: With `cfg_mode[2]` = 1, the next pass starts (`conv_start` for slot 0) in the cycle after the last result is stored and overwrites the slots. Completion flags stay set until the next control write.
- R10: `conv_start` is a one-cycle pulse. No further start is issued until `conv_done` is accepted, and the next start of the same pass comes in the cycle after that acceptance.
- R11: A control write aborts a pass in progress. In the write cycle no `conv_start` is issued, and a `conv_done` arriving in that cycle is not stored.
- R12: A `conv_done` arriving while no conversion is outstanding changes no result slot and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_chan | input | 4 | Channel field |
| cfg_mode | input | 3 | Mode code {repeat, block, eight} |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_sel | output | 4 | Multiplexer select for the requested conversion |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 10 | Converter result |
| res_flat | output | 80 | Eight 10-bit result slots, slot n at bits 10n+9:10n |
| slot_done | output | 8 | Per-slot completion flags |
| seq_done | output | 1 | Pass-complete flag |

## Verification
The assertions take for granted that the converter never raises `conv_done` for a conversion the controller did not start. They also take for granted that the converter drops an outstanding conversion when it sees the same control write that aborts the pass, so no stale result arrives after an abort. The bench converter keeps to this. It answers each start after a programmable latency of one to four cycles and cancels its pending answer on any write. It raises a spurious `conv_done` only while the controller is idle, and that case is what R12 exercises.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // bit 2: repeat passes, bit 1: channel block, bit 0: eight conversions
  typedef struct packed {
    logic repeat_on;
    logic multi;
    logic long_seq;
  } seq_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } step_state_e;
endpackage

// File: rtl/adc_seq_stepper.sv
module adc_seq_stepper
  import adc_seq_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int SLOTS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CH_W-1:0]          cfg_chan,
  input  logic [2:0]               cfg_mode,
  input  logic                     conv_done,
  output logic                     conv_start,
  output logic [CH_W-1:0]          conv_sel,
  output logic                     wr_en,
  output logic [$clog2(SLOTS)-1:0] wr_slot,
  output logic                     wr_last
);
  localparam int SLOT_W = $clog2(SLOTS);
  typedef logic [SLOT_W-1:0] slot_t;

  function automatic slot_t last_slot_of(input logic long_seq);
    return long_seq ? slot_t'(SLOTS - 1) : slot_t'(SLOTS / 2 - 1);
  endfunction

  function automatic logic [CH_W-1:0] pick_chan(input logic [CH_W-1:0] base,
                                                input seq_mode_t m, input slot_t s);
    logic [CH_W-1:0] low;
    low = m.long_seq ? CH_W'((1 << SLOT_W) - 1) : CH_W'((1 << (SLOT_W - 1)) - 1);
    if (!m.multi) return base;
    return (base & ~low) | (CH_W'(s) & low);
  endfunction

  step_state_e     st_q;
  slot_t           slot_q;
  logic [CH_W-1:0] chan_q;
  seq_mode_t       mode_q;

  // named internal events
  logic accept, at_last;
  assign accept  = (st_q == ST_WAIT) && conv_done && !cfg_we;
  assign at_last = (slot_q == last_slot_of(mode_q.long_seq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      chan_q <= '0;
      mode_q <= '0;
    end else if (cfg_we) begin
      st_q   <= ST_START;
      slot_q <= '0;
      chan_q <= cfg_chan;
      mode_q <= seq_mode_t'(cfg_mode);
    end else begin
      unique case (st_q)
        ST_START: st_q <= ST_WAIT;
        ST_WAIT: if (conv_done) begin
          if (at_last) begin
            slot_q <= '0;
            st_q   <= mode_q.repeat_on ? ST_START : ST_IDLE;
          end else begin
            slot_q <= slot_q + 1'b1;
            st_q   <= ST_START;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_start = (st_q == ST_START) && !cfg_we;
  assign conv_sel   = pick_chan(chan_q, mode_q, slot_q);
  assign wr_en      = accept;
  assign wr_slot    = slot_q;
  assign wr_last    = at_last;

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R8
  single_pass_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && at_last && !mode_q.repeat_on) |=> !conv_start);
  // R9
  repeat_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && at_last && mode_q.repeat_on) |=> (conv_start || cfg_we));
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int RES_W = 10,
  parameter int SLOTS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [$clog2(SLOTS)-1:0] wr_slot,
  input  logic                     wr_last,
  input  logic [RES_W-1:0]         wr_data,
  output logic [SLOTS*RES_W-1:0]   res_flat,
  output logic [SLOTS-1:0]         slot_done,
  output logic                     seq_done
);
  logic [RES_W-1:0] res_q [SLOTS];
  logic [SLOTS-1:0] done_q;
  logic             seq_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (int'(wr_slot) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[g]  <= '0;
        done_q[g] <= 1'b0;
      end else begin
        if (hit) res_q[g] <= wr_data;
        if (clr) done_q[g] <= 1'b0;
        else if (hit) done_q[g] <= 1'b1;
      end
    end
    assign res_flat[g*RES_W +: RES_W] = res_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= 1'b0;
    else if (clr) seq_q <= 1'b0;
    else if (wr_en && wr_last) seq_q <= 1'b1;
  end

  assign slot_done = done_q;
  assign seq_done  = seq_q;

  // R2
  clear_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (slot_done == '0 && !seq_done));
  // R6
  store_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (res_q[$past(wr_slot)] == $past(wr_data)));
  // R9
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((slot_done & $past(slot_done)) == $past(slot_done)));
  // R7
  pass_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> ($countones(slot_done) == SLOTS || $countones(slot_done) == SLOTS / 2));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W  = 4,
  parameter int RES_W = 10,
  parameter int SLOTS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CH_W-1:0]        cfg_chan,
  input  logic [2:0]             cfg_mode,
  output logic                   conv_start,
  output logic [CH_W-1:0]        conv_sel,
  input  logic                   conv_done,
  input  logic [RES_W-1:0]       conv_data,
  output logic [SLOTS*RES_W-1:0] res_flat,
  output logic [SLOTS-1:0]       slot_done,
  output logic                   seq_done
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic              wr_last;

  adc_seq_stepper #(.CH_W(CH_W), .SLOTS(SLOTS)) u_stepper (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_mode(cfg_mode), .conv_done(conv_done), .conv_start(conv_start),
    .conv_sel(conv_sel), .wr_en(wr_en), .wr_slot(wr_slot), .wr_last(wr_last)
  );

  adc_seq_results #(.RES_W(RES_W), .SLOTS(SLOTS)) u_results (
    .clk(clk), .rst_n(rst_n), .clr(cfg_we), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_last(wr_last), .wr_data(conv_data), .res_flat(res_flat),
    .slot_done(slot_done), .seq_done(seq_done)
  );

  // R11
  no_start_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !conv_start);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_chan = '0;
  logic [2:0]  cfg_mode = '0;
  logic        conv_start;
  logic [3:0]  conv_sel;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic [79:0] res_flat;
  logic [7:0]  slot_done;
  logic        seq_done;

  always #4 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_mode(cfg_mode), .conv_start(conv_start), .conv_sel(conv_sel),
    .conv_done(conv_done), .conv_data(conv_data), .res_flat(res_flat),
    .slot_done(slot_done), .seq_done(seq_done)
  );

  int n_cmp = 0, n_bad = 0;
  // reference model state
  int m_st = 0, m_slot = 0, m_chan = 0, m_mode = 0, m_flags = 0, m_sdone = 0;
  int m_res [8];
  // converter model
  int pend = 0, cnt = 0, pval = 0, kseq = 0, lat = 1;
  int we_req = 0, req_chan = 0, req_mode = 0, spur_req = 0;

  task automatic cmp(input int act, input int exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(input int chan, input int mode, input int slot);
    int size;
    if (((mode / 2) % 2) == 0) return chan;
    size = (mode % 2) ? 8 : 4;
    return (chan / size) * size + slot;
  endfunction

  task automatic tick();
    int es;
    @(negedge clk);
    cfg_we   = (we_req != 0);
    cfg_chan = req_chan[3:0];
    cfg_mode = req_mode[2:0];
    we_req   = 0;
    if (pend != 0 && cnt == 0) begin
      conv_done = 1'b1; conv_data = pval[9:0];
    end else if (spur_req != 0) begin
      conv_done = 1'b1; conv_data = 10'h2AA; spur_req = 0;
    end else begin
      conv_done = 1'b0;
    end
    #1;
    es = (rst_n && m_st == 1 && !cfg_we) ? 1 : 0;
    cmp(int'(conv_start), es, "R10 conv_start");
    if (es != 0) cmp(int'(conv_sel), exp_sel(m_chan, m_mode, m_slot), "R4 R5 conv_sel");
    cmp(int'(slot_done), m_flags, "R6 slot_done");
    cmp(int'(seq_done), m_sdone, "R7 seq_done");
    for (int i = 0; i < 8; i++) cmp(int'(res_flat[i*10 +: 10]), m_res[i], "R6 result slot");
    // advance model across the coming edge
    if (!rst_n) begin
      m_st = 0; m_slot = 0; m_chan = 0; m_mode = 0; m_flags = 0; m_sdone = 0; pend = 0;
      for (int i = 0; i < 8; i++) m_res[i] = 0;
    end else if (cfg_we) begin
      m_chan = req_chan; m_mode = req_mode; m_slot = 0; m_st = 1;
      m_flags = 0; m_sdone = 0; pend = 0;
    end else if (m_st == 1) begin
      pval = (exp_sel(m_chan, m_mode, m_slot) * 37 + kseq * 113) % 1024;
      kseq++; pend = 1; cnt = lat - 1; m_st = 2;
    end else if (m_st == 2 && conv_done) begin
      m_res[m_slot] = int'(conv_data);
      m_flags = m_flags | (1 << m_slot);
      pend = 0;
      if (m_slot == ((m_mode % 2) ? 7 : 3)) begin
        m_sdone = 1; m_slot = 0; m_st = (m_mode >= 4) ? 1 : 0;
      end else begin
        m_slot++; m_st = 1;
      end
    end else if (pend != 0) begin
      cnt--;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write_cfg(input int chan, input int mode);
    req_chan = chan; req_mode = mode; we_req = 1;
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [79:0] snap;
    for (int i = 0; i < 8; i++) m_res[i] = 0;
    run(3);
    // R1 reset state
    cmp(int'(|res_flat), 0, "R1 results zero");
    cmp(int'(slot_done), 0, "R1 flags clear");
    cmp(int'(conv_start), 0, "R1 no start");
    rst_n = 1'b1;
    run(2);
    cmp(int'(conv_start), 0, "R1 idle after reset");

    // single channel, four conversions, one pass
    lat = 2; write_cfg(5, 0); tick(); tick();
    cmp(int'(slot_done), 0, "R2 flags cleared");
    cmp(int'(conv_start), 1, "R2 start after write");
    run(20);
    cmp(int'(slot_done), 'h0F, "R3 four slots");
    cmp(int'(seq_done), 1, "R7 pass done");
    tick(); cmp(int'(conv_start), 0, "R8 stopped");

    // spurious done while idle
    snap = res_flat; spur_req = 1; tick(); tick();
    cmp(int'(res_flat == snap), 1, "R12 results kept");
    cmp(int'(slot_done), 'h0F, "R12 flags kept");

    // internal channel, eight conversions
    lat = 1; write_cfg(14, 1); run(25);
    cmp(int'(slot_done), 'hFF, "R3 eight slots");
    // block of four and block of eight
    lat = 3; write_cfg(7, 2); run(25);
    cmp(int'(slot_done), 'h0F, "R5 block of four");
    lat = 1; write_cfg(9, 3); run(25);
    cmp(int'(slot_done), 'hFF, "R5 block of eight");

    // continuous block of four, then abort mid-pass in a start cycle
    lat = 2; write_cfg(2, 6); run(40);
    cmp(int'(slot_done), 'h0F, "R9 flags stay set");
    while (m_st != 1) tick();
    write_cfg(3, 5); tick();
    cmp(int'(conv_start), 0, "R11 start held in write cycle");
    run(30);
    // abort coinciding with a done strobe
    lat = 3;
    while (!(m_st == 2 && pend != 0 && cnt == 0)) tick();
    write_cfg(12, 7); tick(); tick();
    cmp(int'(slot_done), 0, "R11 dropped result");
    lat = 4; run(90);
    cmp(int'(seq_done), 1, "R9 continuous pass done");
    lat = 1; write_cfg(0, 4); run(30);
    write_cfg(6, 0); run(20);
    cmp(int'(conv_start), 0, "R8 idle at end");
    finish_up();
  end
endmodule